// File: doc/BRIEF.md
# DMA Read Controller

This block steers a host-to-local DMA read. A single start command gives a host byte address and a byte length. The controller cuts the transfer into read requests of at most 128 bytes each. Every request after the first moves the address on by 128. The requests leave on a valid/ready request port. Completions that come back are counted, and each data beat is passed to a local write port together with its byte offset inside the transfer. Two counters track how busy the link is: one counts header beats and one counts payload beats. Every request costs an 8-byte header, which is two 4-byte beats.

Status is reported as exactly one of idle, busy, done or error. A one-cycle pulse marks the completion of a transfer. Three faults end a transfer in a sticky error state, and a 2-bit code records which fault it was. The first fault is a start whose length is zero or not a multiple of 4. The second is a start that arrives while a transfer is running. The third is a completion that carries no data. The only way out of the error state is a new, valid start. A synchronous reset returns the block to idle.

Top module: `dma_rd_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, idle_o is 1, every other status output is 0, err_cause_o is 0, req_valid_o and wr_en_o are 0, and both beat counters read 0.
- R2: A start whose length is non-zero and a multiple of 4 is accepted from idle, done or error. On the next cycle busy_o is 1, error_o and done_o are 0, err_cause_o is 0 and both beat counters are 0.
- R3: While busy, the block issues requests of min(remaining bytes, 128). The n-th request (counting from 0) carries address start + 128·n. A request holds its address and length steady until req_ready_i is sampled high.
- R4: A start with a length of zero, or with length bits [1:0] not equal to 0, when not busy, moves the block to error with err_cause_o = 1 and issues no request.
- R5: A start that is sampled while busy moves the block to error with err_cause_o = 2 on the next cycle. busy_o and req_valid_o drop in that same cycle.
- R6: A completion with cpl_nodata_i = 1 while busy moves the block to error with err_cause_o = 3, and produces no write.
- R7: Each data completion accepted while busy produces, on the next cycle, wr_en_o = 1 with that data. wr_off_o equals the number of bytes received before that beat, and each beat is 4 bytes.
- R8: When the received byte count reaches the requested length, the block enters done. In that same cycle done_pulse_o is high for exactly one cycle and busy_o is low.
- R9: In error, completions and request handshakes leave the state and err_cause_o unchanged and produce no write, until a valid start arrives.
- R10: Each issued request adds 2 to hdr_beats_o and adds its length divided by 4 to pld_beats_o.
- R11: Completions in idle or done, with or without data, produce no write and change no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start command strobe |
| start_addr_i | input | 32 | Host byte address of the transfer |
| start_len_i | input | 16 | Transfer length in bytes |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Read request accepted |
| req_addr_o | output | 32 | Host address of the current request |
| req_len_o | output | 8 | Byte length of the current request (4..128) |
| cpl_valid_i | input | 1 | Completion beat present |
| cpl_nodata_i | input | 1 | Completion carries no data |
| cpl_data_i | input | 32 | Completion data, 4 bytes |
| wr_en_o | output | 1 | Local write strobe |
| wr_off_o | output | 16 | Byte offset of the write inside the transfer |
| wr_data_o | output | 32 | Local write data |
| idle_o | output | 1 | Engine idle |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Last transfer finished |
| done_pulse_o | output | 1 | One-cycle pulse when a transfer finishes |
| error_o | output | 1 | Sticky error state |
| err_cause_o | output | 2 | 0 none, 1 bad length, 2 start while busy, 3 completion without data |
| hdr_beats_o | output | 16 | Header beats used by requests of this transfer |
| pld_beats_o | output | 16 | Payload beats requested in this transfer |

## Verification
The checks on request stability and on single done pulses assume that a transfer's last completion does not arrive while a request is still waiting for ready. They also assume that completions arrive only after the requests that caused them. The stimulus keeps to this: it issues every request of a transfer before it returns any completion beat, and it raises start only when it means to test a fresh transfer or the start-while-busy fault. Lengths in the table cover a single beat, exactly one full request, one beat past a full request, several full requests, and a short final request.

// File: rtl/dma_rd_pkg.sv
package dma_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2,
        ST_ERR  = 2'd3
    } dma_st_e;

    typedef enum logic [1:0] {
        EC_NONE    = 2'd0,
        EC_BADLEN  = 2'd1,
        EC_OVERLAP = 2'd2,
        EC_NODATA  = 2'd3
    } dma_err_e;

endpackage

// File: rtl/dma_seg.sv
// Request segmenter: walks address and remaining length in payload-sized steps.
module dma_seg #(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 16,
    parameter int MAX_PLD = 128,
    parameter int PLD_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              active,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [PLD_W-1:0]  req_len,
    output logic              fire
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
    } seg_t;

    seg_t s_d, s_q;

    always_comb begin
        req_valid = active && (s_q.remain != '0);
        req_addr  = s_q.addr;
        if (s_q.remain > LEN_W'(MAX_PLD)) begin
            req_len = PLD_W'(MAX_PLD);
        end else begin
            req_len = s_q.remain[PLD_W-1:0];
        end
        fire = req_valid && req_ready;

        s_d = s_q;
        if (load) begin
            s_d.addr   = load_addr;
            s_d.remain = load_len;
        end else if (fire) begin
            s_d.addr   = s_q.addr + ADDR_W'(MAX_PLD);
            s_d.remain = s_q.remain - LEN_W'(req_len);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/dma_cpl.sv
// Completion accounting and local write port.
module dma_cpl #(
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              active,
    input  logic              block,
    input  logic              cpl_valid,
    input  logic              cpl_nodata,
    input  logic [DATA_W-1:0] cpl_data,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic              wr_en,
    output logic [LEN_W-1:0]  wr_off,
    output logic [DATA_W-1:0] wr_data,
    output logic              last_beat,
    output logic              nodata_hit
);

    localparam int BEAT_BYTES = DATA_W / 8;

    typedef struct packed {
        logic [LEN_W-1:0]  rcv;
        logic              wen;
        logic [LEN_W-1:0]  off;
        logic [DATA_W-1:0] data;
    } cpl_t;

    cpl_t c_d, c_q;
    logic accept;
    logic [LEN_W:0] rcv_next;

    always_comb begin
        accept     = active && !block && cpl_valid && !cpl_nodata;
        nodata_hit = active && !block && cpl_valid && cpl_nodata;
        rcv_next   = {1'b0, c_q.rcv} + (LEN_W+1)'(BEAT_BYTES);
        last_beat  = accept && (rcv_next == {1'b0, xfer_len});

        c_d     = c_q;
        c_d.wen = 1'b0;
        if (clear) begin
            c_d.rcv = '0;
        end else if (accept) begin
            c_d.wen  = 1'b1;
            c_d.off  = c_q.rcv;
            c_d.data = cpl_data;
            c_d.rcv  = rcv_next[LEN_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign wr_en   = c_q.wen;
    assign wr_off  = c_q.off;
    assign wr_data = c_q.data;

endmodule

// File: rtl/dma_link_acct.sv
// Link occupancy accounting: header and payload beats kept apart.
module dma_link_acct #(
    parameter int LEN_W     = 16,
    parameter int PLD_W     = 8,
    parameter int HDR_BEATS = 2,
    parameter int BEAT_SH   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             fire,
    input  logic [PLD_W-1:0] req_len,
    output logic [LEN_W-1:0] hdr_beats,
    output logic [LEN_W-1:0] pld_beats
);

    typedef struct packed {
        logic [LEN_W-1:0] hdr;
        logic [LEN_W-1:0] pld;
    } acct_t;

    acct_t a_d, a_q;
    logic [PLD_W-1:0] req_beats;

    always_comb begin
        req_beats = req_len >> BEAT_SH;
        a_d = a_q;
        if (clear) begin
            a_d = '0;
        end else if (fire) begin
            a_d.hdr = a_q.hdr + LEN_W'(HDR_BEATS);
            a_d.pld = a_q.pld + LEN_W'(req_beats);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign hdr_beats = a_q.hdr;
    assign pld_beats = a_q.pld;

endmodule

// File: rtl/dma_rd_ctrl.sv
// DMA read controller top: state machine, error capture and sub-unit wiring.
module dma_rd_ctrl
    import dma_rd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int DATA_W    = 32,
    parameter int MAX_PLD   = 128,
    parameter int HDR_BYTES = 8,
    parameter int PLD_W     = $clog2(MAX_PLD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [LEN_W-1:0]  start_len_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [PLD_W-1:0]  req_len_o,
    input  logic              cpl_valid_i,
    input  logic              cpl_nodata_i,
    input  logic [DATA_W-1:0] cpl_data_i,
    output logic              wr_en_o,
    output logic [LEN_W-1:0]  wr_off_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              idle_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              done_pulse_o,
    output logic              error_o,
    output logic [1:0]        err_cause_o,
    output logic [LEN_W-1:0]  hdr_beats_o,
    output logic [LEN_W-1:0]  pld_beats_o
);

    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int BEAT_SH    = $clog2(BEAT_BYTES);
    localparam int HDR_BEATS  = HDR_BYTES / BEAT_BYTES;

    typedef struct packed {
        dma_st_e          st;
        dma_err_e         cause;
        logic [LEN_W-1:0] len;
        logic             pulse;
    } ctl_t;

    ctl_t r_d, r_q;

    logic len_ok;
    logic load;
    logic is_busy;
    logic seg_fire;
    logic last_beat;
    logic nodata_hit;

    always_comb begin
        len_ok  = (start_len_i != '0) && (start_len_i[BEAT_SH-1:0] == '0);
        is_busy = (r_q.st == ST_BUSY);
        load    = start_i && !is_busy && len_ok;

        r_d       = r_q;
        r_d.pulse = 1'b0;
        case (r_q.st)
            ST_BUSY: begin
                if (start_i) begin
                    r_d.st    = ST_ERR;
                    r_d.cause = EC_OVERLAP;
                end else if (nodata_hit) begin
                    r_d.st    = ST_ERR;
                    r_d.cause = EC_NODATA;
                end else if (last_beat) begin
                    r_d.st    = ST_DONE;
                    r_d.pulse = 1'b1;
                end
            end
            default: begin
                if (start_i) begin
                    if (len_ok) begin
                        r_d.st    = ST_BUSY;
                        r_d.cause = EC_NONE;
                        r_d.len   = start_len_i;
                    end else begin
                        r_d.st    = ST_ERR;
                        r_d.cause = EC_BADLEN;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, cause: EC_NONE, len: '0, pulse: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    dma_seg #(
        .ADDR_W  (ADDR_W),
        .LEN_W   (LEN_W),
        .MAX_PLD (MAX_PLD),
        .PLD_W   (PLD_W)
    ) u_seg (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_addr (start_addr_i),
        .load_len  (start_len_i),
        .active    (is_busy),
        .req_ready (req_ready_i),
        .req_valid (req_valid_o),
        .req_addr  (req_addr_o),
        .req_len   (req_len_o),
        .fire      (seg_fire)
    );

    dma_cpl #(
        .LEN_W  (LEN_W),
        .DATA_W (DATA_W)
    ) u_cpl (
        .clk        (clk),
        .rst        (rst),
        .clear      (load),
        .active     (is_busy),
        .block      (start_i),
        .cpl_valid  (cpl_valid_i),
        .cpl_nodata (cpl_nodata_i),
        .cpl_data   (cpl_data_i),
        .xfer_len   (r_q.len),
        .wr_en      (wr_en_o),
        .wr_off     (wr_off_o),
        .wr_data    (wr_data_o),
        .last_beat  (last_beat),
        .nodata_hit (nodata_hit)
    );

    dma_link_acct #(
        .LEN_W     (LEN_W),
        .PLD_W     (PLD_W),
        .HDR_BEATS (HDR_BEATS),
        .BEAT_SH   (BEAT_SH)
    ) u_acct (
        .clk       (clk),
        .rst       (rst),
        .clear     (load),
        .fire      (seg_fire),
        .req_len   (req_len_o),
        .hdr_beats (hdr_beats_o),
        .pld_beats (pld_beats_o)
    );

    assign idle_o       = (r_q.st == ST_IDLE);
    assign busy_o       = is_busy;
    assign done_o       = (r_q.st == ST_DONE);
    assign error_o      = (r_q.st == ST_ERR);
    assign err_cause_o  = r_q.cause;
    assign done_pulse_o = r_q.pulse;

endmodule

// File: rtl/dma_rd_ctrl_chk.sv
// Property checker, attached to every dma_rd_ctrl instance.
module dma_rd_ctrl_chk #(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 16,
    parameter int MAX_PLD = 128,
    parameter int PLD_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [LEN_W-1:0]  start_len_i,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [PLD_W-1:0]  req_len_o,
    input logic              cpl_valid_i,
    input logic              cpl_nodata_i,
    input logic              wr_en_o,
    input logic              idle_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              done_pulse_o,
    input logic              error_o,
    input logic [1:0]        err_cause_o,
    input logic [LEN_W-1:0]  hdr_beats_o
);

    a_r1_one_status: assert property (@(posedge clk) disable iff (rst)
        $countones({idle_o, busy_o, done_o, error_o}) == 1);

    a_r3_req_len_bound: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> (req_len_o != '0) && (req_len_o <= PLD_W'(MAX_PLD))
                        && (req_len_o[1:0] == 2'b00));

    a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && !req_ready_i && !start_i && !cpl_valid_i)
        |=> req_valid_o && $stable(req_addr_o) && $stable(req_len_o));

    a_r4_bad_len: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && ((start_len_i == '0) || (start_len_i[1:0] != 2'b00)))
        |=> error_o && (err_cause_o == 2'd1) && !req_valid_o);

    a_r5_overlap: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy_o) |=> error_o && (err_cause_o == 2'd2) && !busy_o && !req_valid_o);

    a_r6_nodata: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cpl_valid_i && cpl_nodata_i && !start_i)
        |=> error_o && (err_cause_o == 2'd3) && !wr_en_o);

    a_r7_write_source: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> $past(cpl_valid_i) && !$past(cpl_nodata_i) && $past(busy_o));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done_pulse_o |-> done_o ##1 !done_pulse_o);

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (error_o && !start_i) |=> error_o && $stable(err_cause_o) && !wr_en_o);

    a_r10_hdr_step: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && req_ready_i) |=> hdr_beats_o == $past(hdr_beats_o) + LEN_W'(2));

    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        ((idle_o || done_o) && !start_i) |=> !wr_en_o && $stable(idle_o) && $stable(done_o));

endmodule

bind dma_rd_ctrl dma_rd_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .LEN_W   (LEN_W),
    .MAX_PLD (MAX_PLD),
    .PLD_W   (PLD_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .start_len_i  (start_len_i),
    .req_valid_o  (req_valid_o),
    .req_ready_i  (req_ready_i),
    .req_addr_o   (req_addr_o),
    .req_len_o    (req_len_o),
    .cpl_valid_i  (cpl_valid_i),
    .cpl_nodata_i (cpl_nodata_i),
    .wr_en_o      (wr_en_o),
    .idle_o       (idle_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .done_pulse_o (done_pulse_o),
    .error_o      (error_o),
    .err_cause_o  (err_cause_o),
    .hdr_beats_o  (hdr_beats_o)
);

// File: tb/dma_rd_ctrl_tb.sv
module dma_rd_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic [15:0] start_len_i = '0;
    logic        req_valid_o;
    logic        req_ready_i = 1'b0;
    logic [31:0] req_addr_o;
    logic [7:0]  req_len_o;
    logic        cpl_valid_i = 1'b0;
    logic        cpl_nodata_i = 1'b0;
    logic [31:0] cpl_data_i = '0;
    logic        wr_en_o;
    logic [15:0] wr_off_o;
    logic [31:0] wr_data_o;
    logic        idle_o, busy_o, done_o, done_pulse_o, error_o;
    logic [1:0]  err_cause_o;
    logic [15:0] hdr_beats_o, pld_beats_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    dma_rd_ctrl u_dut (
        .clk(clk), .rst(rst),
        .start_i(start_i), .start_addr_i(start_addr_i), .start_len_i(start_len_i),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_addr_o(req_addr_o), .req_len_o(req_len_o),
        .cpl_valid_i(cpl_valid_i), .cpl_nodata_i(cpl_nodata_i), .cpl_data_i(cpl_data_i),
        .wr_en_o(wr_en_o), .wr_off_o(wr_off_o), .wr_data_o(wr_data_o),
        .idle_o(idle_o), .busy_o(busy_o), .done_o(done_o), .done_pulse_o(done_pulse_o),
        .error_o(error_o), .err_cause_o(err_cause_o),
        .hdr_beats_o(hdr_beats_o), .pld_beats_o(pld_beats_o)
    );

    // address, length
    localparam logic [47:0] VEC [5] = '{
        {32'h0000_1000, 16'd4},
        {32'h0000_2000, 16'd128},
        {32'h0001_3000, 16'd132},
        {32'h0000_4000, 16'd512},
        {32'h00A0_5F00, 16'd300}
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_start(input logic [31:0] a, input logic [15:0] l);
        start_i = 1'b1; start_addr_i = a; start_len_i = l;
        tick();
        start_i = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        tick(); tick(); tick();
        // R1 reset state
        check(idle_o && !busy_o && !done_o && !error_o && !done_pulse_o, "R1 status", {busy_o, done_o, error_o, idle_o}, 4'b0001);
        check(!req_valid_o && !wr_en_o && err_cause_o == 0, "R1 outputs", {req_valid_o, wr_en_o, err_cause_o}, 0);
        check(hdr_beats_o == 0 && pld_beats_o == 0, "R1 counters", {hdr_beats_o, pld_beats_o}, 0);
        rst = 1'b0;
        tick();
        check(idle_o && !req_valid_o, "R1 after reset", {idle_o, req_valid_o}, 2'b10);

        // R11 completions in idle
        cpl_valid_i = 1'b1; cpl_data_i = 32'hDEAD_BEEF; tick();
        cpl_nodata_i = 1'b1; tick();
        check(!wr_en_o && idle_o && !error_o, "R11 idle completion", {wr_en_o, idle_o, error_o}, 3'b010);
        cpl_valid_i = 1'b0; cpl_nodata_i = 1'b0; tick();
        check(!wr_en_o && idle_o, "R11 idle no write", {wr_en_o, idle_o}, 2'b01);

        // table of transfers
        for (int v = 0; v < 5; v++) begin
            logic [31:0] a;
            logic [15:0] l;
            int rem, nreq, nbeat;
            a = VEC[v][47:16];
            l = VEC[v][15:0];
            nreq = (int'(l) + 127) / 128;
            nbeat = int'(l) / 4;
            do_start(a, l);
            check(busy_o && !idle_o && !done_o && !error_o && err_cause_o == 0, "R2 busy after start",
                  {busy_o, idle_o, done_o, error_o}, 4'b1000);
            check(hdr_beats_o == 0 && pld_beats_o == 0 && !done_pulse_o, "R2 counters cleared",
                  {hdr_beats_o, pld_beats_o}, 0);
            rem = int'(l);
            for (int i = 0; i < nreq; i++) begin
                int el;
                el = (rem > 128) ? 128 : rem;
                if (i % 2 == 1) begin
                    req_ready_i = 1'b0; tick();
                    check(req_valid_o && req_addr_o == a + 32'(128 * i) && req_len_o == 8'(el),
                          "R3 hold while not ready", {req_valid_o, req_addr_o, req_len_o}, {1'b1, a + 32'(128 * i), 8'(el)});
                end
                check(req_valid_o && req_addr_o == a + 32'(128 * i) && req_len_o == 8'(el),
                      "R3 request", {req_valid_o, req_addr_o, req_len_o}, {1'b1, a + 32'(128 * i), 8'(el)});
                req_ready_i = 1'b1; tick(); req_ready_i = 1'b0;
                rem -= el;
            end
            check(!req_valid_o, "R3 no extra request", req_valid_o, 0);
            check(hdr_beats_o == 16'(2 * nreq), "R10 header beats", hdr_beats_o, 2 * nreq);
            check(pld_beats_o == 16'(nbeat), "R10 payload beats", pld_beats_o, nbeat);
            for (int b = 0; b < nbeat; b++) begin
                logic [31:0] d;
                d = {a[15:0], 16'(b)} ^ 32'h5A5A_0000;
                if (b % 3 == 2) begin
                    cpl_valid_i = 1'b0; tick();
                    check(!wr_en_o, "R7 gap no write", wr_en_o, 0);
                end
                cpl_valid_i = 1'b1; cpl_data_i = d; tick();
                check(wr_en_o && wr_off_o == 16'(4 * b) && wr_data_o == d, "R7 write",
                      {wr_en_o, wr_off_o, wr_data_o}, {1'b1, 16'(4 * b), d});
                if (b == nbeat - 1) begin
                    check(done_pulse_o && done_o && !busy_o, "R8 done", {done_pulse_o, done_o, busy_o}, 3'b110);
                end else begin
                    check(!done_pulse_o && busy_o, "R8 not yet done", {done_pulse_o, busy_o}, 2'b01);
                end
            end
            cpl_valid_i = 1'b0; tick();
            check(!done_pulse_o && done_o && !wr_en_o, "R8 pulse one cycle", {done_pulse_o, done_o, wr_en_o}, 3'b010);
        end

        // R11 completions in done
        cpl_valid_i = 1'b1; cpl_nodata_i = 1'b1; tick();
        cpl_nodata_i = 1'b0; tick();
        check(done_o && !error_o && !wr_en_o, "R11 done completion", {done_o, error_o, wr_en_o}, 3'b100);
        cpl_valid_i = 1'b0; tick();
        check(done_o && !wr_en_o, "R11 done no write", {done_o, wr_en_o}, 2'b10);

        // R4 zero and unaligned length
        do_start(32'h100, 16'd0);
        check(error_o && err_cause_o == 1 && !req_valid_o, "R4 zero length", {error_o, err_cause_o, req_valid_o}, 4'b1010);
        do_start(32'h100, 16'd6);
        check(error_o && err_cause_o == 1 && !req_valid_o, "R4 unaligned length", {error_o, err_cause_o, req_valid_o}, 4'b1010);

        // R2 recovery from error
        do_start(32'h8000, 16'd8);
        check(busy_o && !error_o && err_cause_o == 0 && req_valid_o, "R2 recover from error",
              {busy_o, error_o, err_cause_o, req_valid_o}, 5'b10001);

        // R5 start while busy
        do_start(32'h9000, 16'd8);
        check(error_o && err_cause_o == 2 && !busy_o && !req_valid_o, "R5 start while busy",
              {error_o, err_cause_o, busy_o, req_valid_o}, 5'b11000);

        // R9 sticky error
        cpl_valid_i = 1'b1; cpl_data_i = 32'h1234_5678; req_ready_i = 1'b1; tick();
        tick();
        check(error_o && err_cause_o == 2 && !wr_en_o, "R9 sticky", {error_o, err_cause_o, wr_en_o}, 4'b1100);
        cpl_valid_i = 1'b0; req_ready_i = 1'b0; tick();
        check(error_o && !wr_en_o && !req_valid_o, "R9 still error", {error_o, wr_en_o, req_valid_o}, 3'b100);

        // R6 completion without data
        do_start(32'hA000, 16'd16);
        cpl_valid_i = 1'b1; cpl_data_i = 32'hCAFE_0001; tick();
        check(wr_en_o && wr_off_o == 0 && busy_o, "R7 first beat", {wr_en_o, wr_off_o, busy_o}, {1'b1, 16'd0, 1'b1});
        cpl_nodata_i = 1'b1; tick();
        check(error_o && err_cause_o == 3 && !wr_en_o && !busy_o, "R6 no-data completion",
              {error_o, err_cause_o, wr_en_o, busy_o}, 5'b11100);
        cpl_valid_i = 1'b0; cpl_nodata_i = 1'b0; tick();
        check(error_o && err_cause_o == 3, "R9 cause kept", {error_o, err_cause_o}, 3'b111);

        // R1 reset in the middle of a transfer
        do_start(32'hB000, 16'd64);
        rst = 1'b1; tick(); rst = 1'b0;
        check(idle_o && !busy_o && !req_valid_o && hdr_beats_o == 0 && err_cause_o == 0, "R1 reset mid transfer",
              {idle_o, busy_o, req_valid_o}, 3'b100);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule